// File: doc/BRIEF.md
# Soft Mute Gain Ramp

The block sits in a stereo audio path between the serial input stage and the interpolation filter. Each frame (one left/right sample pair) arrives with a one-cycle strobe. The block multiplies both samples by a shared gain level. When mute is requested, the gain steps linearly down to zero over a fixed number of frames. When mute is removed, the gain steps back up to full scale over the same number of frames. The ramp length depends on the speed mode: it doubles in double speed and quadruples in quad speed, so the ramp takes about the same wall time in every mode.

The block also drives an active-low mute-control output for an external analog mute switch. This output goes low only when the gain has actually reached zero. It goes high again on the clock after mute is removed, before the up-ramp starts to produce audible signal. The output is also held low during reset, power-down, the short initialization period after either of them, and whenever the clock-ratio error flag is set.

Top module: `soft_mute_ramp`

## Requirements
- R1: The mute request `mute_ni` is active low (0 = mute, 1 = play). The gain level changes only on a cycle in which `frame_i` is high.
- R2: Speed mode `mode_i` encodes 00 = single, 01 = double, 10 or 11 = quad. A full ramp between zero and full scale takes exactly 1152, 2304 or 4608 frames respectively. The gain step is 4, 2 or 1 units of a 4608-unit full scale.
- R3: Each output sample equals the input sample times level/4608, truncated toward zero. The same level is applied to both channels. The result is registered on the strobe cycle, using the level held before that frame's step, and `out_valid_o` pulses in the following cycle. At full level the output equals the input.
- R4: During a down-ramp `mute_ctl_no` stays high. It goes low in the cycle after the strobe that brings the level to zero.
- R5: When `mute_ni` rises while muted, `mute_ctl_no` goes high on the next clock. The level then rises one step per frame until it reaches full scale.
- R6: If `mute_ni` changes mid-ramp, the ramp reverses direction from the present level, with no jump.
- R7: The step size is latched whenever a ramp starts, including on a reversal. A change of `mode_i` during a ramp does not alter that ramp's step.
- R8: While `pd_i` is high, the level is forced to zero, the block is muted and `mute_ctl_no` is low. After `pd_i` falls, or after reset, two initialization frames pass at zero level with `mute_ctl_no` low. An up-ramp then starts if `mute_ni` is high.
- R9: While `ratio_err_i` is high, `mute_ctl_no` is low, and the gain and ramp state are not affected.
- R10: While `rst_ni` is low, both sample outputs are zero, `out_valid_o` is low and `mute_ctl_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_i | input | 1 | Power-down; forces mute at zero level |
| ratio_err_i | input | 1 | Master-clock to frame-rate ratio invalid |
| mute_ni | input | 1 | Mute request, active low |
| mode_i | input | 2 | Speed mode: 00 single, 01 double, 1x quad |
| frame_i | input | 1 | One-cycle strobe per frame, samples valid |
| left_i | input | 24 | Left sample, two's complement |
| right_i | input | 24 | Right sample, two's complement |
| left_o | output | 24 | Scaled left sample |
| right_o | output | 24 | Scaled right sample |
| out_valid_o | output | 1 | Pulses one cycle after each strobe |
| mute_ctl_no | output | 1 | External mute control, active low |

## Verification
The gain level is internal, so the bench feeds constant samples chosen so that each output is an exact integer multiple of the level. This lets every frame expose the level directly at the ports. Each stimulus is designed so that an internal fault shows up at the ports within a bounded number of frames:
- A wrong step size or a wrong latched mode shows up as a wrong output value on the very next frame.
- A state machine stuck in the wrong direction shows up within one frame.
- A completion detected one frame early or late shows up as `mute_ctl_no` changing on the wrong strobe.
- A failure to reverse, or a jump on reversal, shows up as a discontinuity in the output on the first frame after `mute_ni` toggles.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic [1:0] {
    ST_MUTED = 2'd0,
    ST_UP    = 2'd1,
    ST_FULL  = 2'd2,
    ST_DOWN  = 2'd3
  } ramp_state_e;

  localparam int MODE_W    = 2;
  localparam int MAX_SHIFT = 2;          // quad = single >> 2
  localparam int MAX_STEP  = 1 << MAX_SHIFT;
  localparam int STEP_W    = MAX_SHIFT + 1;
endpackage

// File: rtl/smr_step_sel.sv
module smr_step_sel
  import smr_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic [STEP_W-1:0] step_o
);
  logic [STEP_W-1:0] base;
  assign base = STEP_W'(MAX_STEP);

  always_comb begin
    unique case (mode_i)
      2'd0:    step_o = base;
      2'd1:    step_o = base >> 1;
      default: step_o = base >> MAX_SHIFT;
    endcase
  end
endmodule

// File: rtl/smr_gain_ctrl.sv
module smr_gain_ctrl
  import smr_pkg::*;
#(
  parameter int FULL_LEVEL  = 4608,
  parameter int INIT_FRAMES = 2,
  localparam int LEVEL_W    = $clog2(FULL_LEVEL + 1),
  localparam int INIT_W     = (INIT_FRAMES > 1) ? $clog2(INIT_FRAMES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pd_i,
  input  logic               unmute_i,
  input  logic               frame_i,
  input  logic [STEP_W-1:0]  step_i,
  output logic [LEVEL_W-1:0] level_o,
  output logic               run_o,
  output logic               muted_o
);
  localparam logic [LEVEL_W-1:0] FULL = LEVEL_W'(FULL_LEVEL);

  ramp_state_e        state_q;
  logic [LEVEL_W-1:0] level_q;
  logic [STEP_W-1:0]  step_q;
  logic [INIT_W-1:0]  init_q;
  logic               run_q;
  logic [LEVEL_W:0]   sum;
  logic [LEVEL_W-1:0] step_ext;

  assign step_ext = LEVEL_W'(step_q);
  assign sum      = {1'b0, level_q} + {1'b0, step_ext};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_MUTED;
      level_q <= '0;
      step_q  <= '0;
      init_q  <= '0;
      run_q   <= 1'b0;
    end else if (pd_i) begin
      state_q <= ST_MUTED;
      level_q <= '0;
      init_q  <= '0;
      run_q   <= 1'b0;
    end else if (!run_q) begin
      if (frame_i) begin
        if (init_q == INIT_W'(INIT_FRAMES - 1)) run_q <= 1'b1;
        else init_q <= init_q + 1'b1;
      end
    end else begin
      unique case (state_q)
        ST_MUTED: if (unmute_i) begin
          state_q <= ST_UP;
          step_q  <= step_i;
        end
        ST_UP: begin
          if (!unmute_i) begin
            state_q <= ST_DOWN;
            step_q  <= step_i;
          end else if (frame_i) begin
            if (sum >= {1'b0, FULL}) begin
              level_q <= FULL;
              state_q <= ST_FULL;
            end else begin
              level_q <= sum[LEVEL_W-1:0];
            end
          end
        end
        ST_FULL: if (!unmute_i) begin
          state_q <= ST_DOWN;
          step_q  <= step_i;
        end
        ST_DOWN: begin
          if (unmute_i) begin
            state_q <= ST_UP;
            step_q  <= step_i;
          end else if (frame_i) begin
            if (level_q <= step_ext) begin
              level_q <= '0;
              state_q <= ST_MUTED;
            end else begin
              level_q <= level_q - step_ext;
            end
          end
        end
        default: state_q <= ST_MUTED;
      endcase
    end
  end

  assign level_o = level_q;
  assign run_o   = run_q;
  assign muted_o = (state_q == ST_MUTED);

  AST_LEVEL_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= FULL) else $error("level above full scale"); // R3
  AST_HOLD_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_i && !pd_i) |=> $stable(level_q)) else $error("level moved without strobe"); // R1
  AST_STEP_SMALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !pd_i) |=> (((level_q >= $past(level_q)) ? (level_q - $past(level_q))
                             : ($past(level_q) - level_q)) <= LEVEL_W'(MAX_STEP)))
    else $error("level jumped"); // R6
  AST_MUTED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MUTED) |-> (level_q == '0)) else $error("muted with nonzero level"); // R4
  AST_PD_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (level_q == '0 && state_q == ST_MUTED && !run_q)) else $error("power-down ignored"); // R8
  AST_UNMUTE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MUTED && unmute_i && run_q && !pd_i) |=> (state_q == ST_UP))
    else $error("unmute did not start ramp"); // R5
endmodule

// File: rtl/smr_scale.sv
module smr_scale #(
  parameter int SAMPLE_W   = 24,
  parameter int FULL_LEVEL = 4608,
  localparam int LEVEL_W   = $clog2(FULL_LEVEL + 1),
  localparam int PROD_W    = SAMPLE_W + LEVEL_W + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       frame_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [LEVEL_W-1:0]         level_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  localparam logic signed [PROD_W-1:0] DIV = PROD_W'(FULL_LEVEL);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] quo;

  assign prod = PROD_W'(sample_i) * $signed({{(PROD_W-LEVEL_W){1'b0}}, level_i});
  assign quo  = prod / DIV;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sample_o <= '0;
    else if (frame_i) sample_o <= quo[SAMPLE_W-1:0];
  end

  AST_FULL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && level_i == LEVEL_W'(FULL_LEVEL)) |=> (sample_o == $past(sample_i)))
    else $error("full level not transparent"); // R3
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import smr_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int BASE_FRAMES = 1152,
  parameter int INIT_FRAMES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pd_i,
  input  logic                ratio_err_i,
  input  logic                mute_ni,
  input  logic [1:0]          mode_i,
  input  logic                frame_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                out_valid_o,
  output logic                mute_ctl_no
);
  localparam int FULL_LEVEL = BASE_FRAMES * MAX_STEP;
  localparam int LEVEL_W    = $clog2(FULL_LEVEL + 1);
  localparam int N_CH       = 2;

  logic [STEP_W-1:0]   step;
  logic [LEVEL_W-1:0]  level;
  logic                run, muted;
  logic [SAMPLE_W-1:0] ch_in  [N_CH];
  logic [SAMPLE_W-1:0] ch_out [N_CH];
  logic                valid_q;

  smr_step_sel u_step (
    .mode_i (mode_i),
    .step_o (step)
  );

  smr_gain_ctrl #(
    .FULL_LEVEL  (FULL_LEVEL),
    .INIT_FRAMES (INIT_FRAMES)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pd_i     (pd_i),
    .unmute_i (mute_ni),
    .frame_i  (frame_i),
    .step_i   (step),
    .level_o  (level),
    .run_o    (run),
    .muted_o  (muted)
  );

  assign ch_in[0] = left_i;
  assign ch_in[1] = right_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    smr_scale #(
      .SAMPLE_W   (SAMPLE_W),
      .FULL_LEVEL (FULL_LEVEL)
    ) u_scale (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .frame_i  (frame_i),
      .sample_i (ch_in[c]),
      .level_i  (level),
      .sample_o (ch_out[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= frame_i;
  end

  assign left_o      = ch_out[0];
  assign right_o     = ch_out[1];
  assign out_valid_o = valid_q;
  assign mute_ctl_no = run && !pd_i && !ratio_err_i && !muted;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> out_valid_o) else $error("valid missing"); // R3
  AST_ERR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_err_i |-> !mute_ctl_no) else $error("ratio error not muting"); // R9
endmodule

// File: tb/soft_mute_ramp_test.sv
`timescale 1ns/1ps
module soft_mute_ramp_test;
  localparam longint LS = 4608 * 1000;
  localparam longint RS = -4608 * 500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pd = 1'b0, err = 1'b0, mute_n = 1'b1, frame = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [23:0] lin = 24'(LS), rin = 24'(RS);
  logic [23:0] lout, rout;
  logic        vld, ctl_n;

  int total = 0, bad = 0;
  longint lvl_seen;

  always #2.5 clk = ~clk;

  soft_mute_ramp uut (
    .clk_i(clk), .rst_ni(rst_n), .pd_i(pd), .ratio_err_i(err), .mute_ni(mute_n),
    .mode_i(mode), .frame_i(frame), .left_i(lin), .right_i(rin),
    .left_o(lout), .right_o(rout), .out_valid_o(vld), .mute_ctl_no(ctl_n)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one frame; level read from left output, right must agree
  task automatic frame_go();
    longint l, r;
    @(negedge clk); frame = 1'b1;
    @(negedge clk); frame = 1'b0;
    l = longint'($signed(lout)); r = longint'($signed(rout));
    lvl_seen = l / 1000;
    if (!vld || l != lvl_seen * 1000 || r != -500 * lvl_seen) lvl_seen = -99999;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic ramp(input longint start, input longint step, input int n, input string tag);
    int errs = 0;
    longint first_bad = 0, exp_bad = 0;
    for (int i = 0; i < n; i++) begin
      frame_go();
      if (lvl_seen != start + step * i) begin
        if (errs == 0) begin first_bad = lvl_seen; exp_bad = start + step * i; end
        errs++;
      end
    end
    chk(errs == 0, tag, first_bad, exp_bad);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(lout == 0 && rout == 0, "R10 outputs zero in reset", longint'(lout), 0);
    chk(!ctl_n && !vld, "R10 mute ctl low in reset", longint'(ctl_n), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_powerup();
    frame_go(); chk(lvl_seen == 0 && !ctl_n, "R8 init frame 1", lvl_seen, 0);
    frame_go(); chk(lvl_seen == 0, "R8 init frame 2", lvl_seen, 0);
    chk(ctl_n == 1'b1, "R5 ctl high at ramp start", longint'(ctl_n), 1);
    ramp(0, 4, 1152, "R2 single up ramp 1152 frames");
    frame_go(); chk(lvl_seen == 4608, "R3 full scale passthrough", lvl_seen, 4608);
  endtask

  task automatic t_down_single();
    mute_n = 1'b0;
    ramp(4608, -4, 1151, "R2 single down ramp");
    chk(ctl_n == 1'b1, "R4 ctl high during down ramp", longint'(ctl_n), 1);
    frame_go(); chk(lvl_seen == 4, "R4 last step", lvl_seen, 4);
    chk(ctl_n == 1'b0, "R4 ctl low at ramp end", longint'(ctl_n), 0);
    repeat (6) @(negedge clk);
    frame_go(); chk(lvl_seen == 0, "R1 silent while muted", lvl_seen, 0);
  endtask

  task automatic t_up_single();
    @(negedge clk); mute_n = 1'b1;
    @(negedge clk);
    chk(ctl_n == 1'b1, "R5 ctl released next clock", longint'(ctl_n), 1);
    repeat (9) @(negedge clk);
    chk(ctl_n == 1'b1, "R1 no strobe no change", longint'(ctl_n), 1);
    ramp(0, 4, 1152, "R5 up ramp after unmute");
    frame_go(); chk(lvl_seen == 4608, "R5 full after up ramp", lvl_seen, 4608);
  endtask

  task automatic t_double_quad();
    mode = 2'd1; mute_n = 1'b0;
    ramp(4608, -2, 2303, "R2 double down ramp");
    chk(ctl_n == 1'b1, "R2 double ctl high one frame early", longint'(ctl_n), 1);
    frame_go(); chk(ctl_n == 1'b0 && lvl_seen == 2, "R2 double ends at 2304", longint'(ctl_n), 0);
    mode = 2'd3; mute_n = 1'b1;
    ramp(0, 1, 4608, "R2 quad up ramp (mode 11)");
    frame_go(); chk(lvl_seen == 4608, "R2 quad reaches full at 4608", lvl_seen, 4608);
  endtask

  task automatic t_reverse_mode();
    mode = 2'd0; mute_n = 1'b0;
    ramp(4608, -4, 100, "R6 down before reversal");
    mode = 2'd2;
    ramp(4208, -4, 50, "R7 mode change keeps step");
    mute_n = 1'b1;
    ramp(4008, 1, 20, "R6 reversal continues from level, R7 new step");
    mode = 2'd0;
    ramp(4028, 1, 580, "R7 step held to end");
    frame_go(); chk(lvl_seen == 4608, "R6 reaches full", lvl_seen, 4608);
  endtask

  task automatic t_ratio();
    err = 1'b1;
    @(negedge clk);
    chk(ctl_n == 1'b0, "R9 ctl low on ratio error", longint'(ctl_n), 0);
    frame_go(); chk(lvl_seen == 4608, "R9 gain unaffected", lvl_seen, 4608);
    err = 1'b0;
    @(negedge clk);
    chk(ctl_n == 1'b1, "R9 ctl back high", longint'(ctl_n), 1);
  endtask

  task automatic t_pd();
    pd = 1'b1;
    @(negedge clk);
    chk(ctl_n == 1'b0, "R8 ctl low in power-down", longint'(ctl_n), 0);
    frame_go(); frame_go();
    chk(lvl_seen == 0, "R8 level zero in power-down", lvl_seen, 0);
    pd = 1'b0;
    frame_go(); chk(lvl_seen == 0 && !ctl_n, "R8 init after pd", lvl_seen, 0);
    frame_go(); chk(lvl_seen == 0, "R8 init after pd 2", lvl_seen, 0);
    ramp(0, 4, 3, "R8 up ramp after pd");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_powerup();
    t_down_single();
    t_up_single();
    t_double_quad();
    t_reverse_mode();
    t_ratio();
    t_pd();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule